// File: doc/BRIEF.md
# Parallel Port Register Interface

This block presents a PC-style parallel port as three byte-wide registers on a simple synchronous bus. It holds a data register, a read-only status view and a control register. The data register drives the port data lines. A read of the data register returns whatever is actually on those lines. The control register drives the four handshake outputs, applying the polarity each pin needs. It also holds a direction bit, which releases the data drivers when the port runs in extended mode.

Every asynchronous port input, including the data lines as they are read back, passes through a synchronizer chain of `SYNC_STAGES` flops before it is used. With the interrupt enable bit set, a rising edge on the synchronized acknowledge input produces a single-cycle interrupt pulse. The data bus is split into `pd_out`, `pd_in` and an output enable `pd_oe`, so that the pad ring can build the tri-state buffer.

Top module: `pport_regs`

## Requirements
- R1: A bus write to address 0 loads the data register, and `pd_out` shows the written byte from the next clock edge onward.
- R2: A read at address 0 returns `pd_in` as it was `SYNC_STAGES` clock edges earlier. This is the value on the lines, whether the block or the outside world drives them.
- R3: `pd_oe` is 0 only when `ext_mode` is 1 and control bit 5 is 1. With `ext_mode` at 0, bit 5 has no effect on `pd_oe`.
- R4: A read at address 1 returns the synchronized port inputs in this layout: bit 7 = NOT `busy_in`, bit 6 = `ack_n_in`, bit 5 = `perr_in`, bit 4 = `sel_in`, bit 3 = `fault_n_in`.
- R5: Status bits 2..0 read 0. Writes to address 1 change no register and no output.
- R6: The control register maps to the outputs as follows: `strobe_n` = NOT bit 0, `autofd_n` = NOT bit 1, `init_n` = bit 2, `selectin_n` = NOT bit 3. A read at address 2 returns bits 5..0 as written, with bits 7..6 reading 0.
- R7: When control bit 4 is 1, each rising edge of the synchronized `ack_n_in` raises `irq` for exactly one cycle. A falling edge raises no pulse, and neither does any edge while bit 4 is 0.
- R8: After reset, the data and control registers are 0x00. The outputs are then `pd_out`=0x00, `strobe_n`=1, `autofd_n`=1, `selectin_n`=1, `init_n`=0, `pd_oe`=1 and `irq`=0.
- R9: Address 3 reads 0x00, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (reads are combinational) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| ext_mode | input | 1 | 1 = extended mode, 0 = compatible/nibble |
| pd_in | input | 8 | Sensed port data lines |
| pd_out | output | 8 | Port data to drive |
| pd_oe | output | 1 | Data driver enable |
| busy_in | input | 1 | Busy input |
| ack_n_in | input | 1 | Acknowledge input, active low |
| perr_in | input | 1 | Paper error input |
| sel_in | input | 1 | Select input |
| fault_n_in | input | 1 | Fault input, active low |
| strobe_n | output | 1 | Strobe output |
| autofd_n | output | 1 | Auto feed output |
| selectin_n | output | 1 | Select-in output |
| init_n | output | 1 | Init output |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 instead of the default of 2. Every wait on a status or read-back value therefore has to follow the parameter rather than a fixed two-cycle delay. A bench wire models the port lines, merging `pd_out` and an external driver under `pd_oe`, so read-back covers both the driven case and the released case. Acknowledge edges are applied in both directions with the enable set and cleared, and the bench counts the `irq` cycles.

// File: rtl/pport_regs.sv
module pport_regs #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ext_mode,
  input  logic [7:0] pd_in,
  output logic [7:0] pd_out,
  output logic       pd_oe,
  input  logic       busy_in,
  input  logic       ack_n_in,
  input  logic       perr_in,
  input  logic       sel_in,
  input  logic       fault_n_in,
  output logic       strobe_n,
  output logic       autofd_n,
  output logic       selectin_n,
  output logic       init_n,
  output logic       irq
);
  localparam int NIN = 13;

  logic [7:0]     data_q;
  logic [5:0]     ctrl_q;
  logic [NIN-1:0] sync_q [SYNC_STAGES];
  logic [NIN-1:0] raw, synced;
  logic           ack_prev;
  logic [7:0]     status;

  assign raw    = {busy_in, ack_n_in, perr_in, sel_in, fault_n_in, pd_in};
  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      ctrl_q   <= '0;
      ack_prev <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr_en && addr == 2'd0) data_q <= wdata;
      if (wr_en && addr == 2'd2) ctrl_q <= wdata[5:0];
      ack_prev <= synced[11];
      irq      <= ctrl_q[4] && synced[11] && !ack_prev;
    end
  end

  assign status = {~synced[12], synced[11:8], 3'b000};

  always_comb begin
    rdata = 8'h00;
    unique case (addr)
      2'd0:    rdata = synced[7:0];
      2'd1:    rdata = status;
      2'd2:    rdata = {2'b00, ctrl_q};
      default: rdata = 8'h00;
    endcase
  end

  assign pd_out     = data_q;
  assign pd_oe      = ~(ext_mode & ctrl_q[5]);
  assign strobe_n   = ~ctrl_q[0];
  assign autofd_n   = ~ctrl_q[1];
  assign init_n     =  ctrl_q[2];
  assign selectin_n = ~ctrl_q[3];

  logic unused_rd;
  assign unused_rd = rd_en;

  // R1
  data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> pd_out == $past(wdata));

  // R6
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2) |=> (strobe_n == !$past(wdata[0]) && init_n == $past(wdata[2])));

  // R7
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ctrl_q[4]));

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5
  status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> ($stable(pd_out) && $stable(strobe_n) && $stable(pd_oe)));
endmodule

// File: tb/pport_regs_test.sv
module pport_regs_test;
  localparam int S = 3;
  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0, ext_mode = 0;
  logic [7:0] wdata = 0, rdata, pd_out, ext_drive = 8'h00;
  logic pd_oe, busy_in = 0, ack_n_in = 1, perr_in = 0, sel_in = 0, fault_n_in = 1;
  logic strobe_n, autofd_n, selectin_n, init_n, irq;
  wire  [7:0] pd_line = pd_oe ? pd_out : ext_drive;
  int checks = 0, fails = 0, irq_cycles = 0;

  always #10 clk = ~clk;
  always @(posedge clk) if (irq) irq_cycles++;

  pport_regs #(.SYNC_STAGES(S)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .ext_mode(ext_mode), .pd_in(pd_line),
    .pd_out(pd_out), .pd_oe(pd_oe), .busy_in(busy_in), .ack_n_in(ack_n_in),
    .perr_in(perr_in), .sel_in(sel_in), .fault_n_in(fault_n_in),
    .strobe_n(strobe_n), .autofd_n(autofd_n), .selectin_n(selectin_n),
    .init_n(init_n), .irq(irq));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata; rd_en = 0;
  endtask

  task automatic settle();
    repeat (S + 1) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R8 pd_out", pd_out, 8'h00);
    chk("R8 outputs", {strobe_n, autofd_n, selectin_n, init_n, pd_oe, irq}, 6'b111010);
  endtask

  task automatic t_data();
    logic [7:0] d;
    wr(0, 8'h3C); chk("R1 pd_out", pd_out, 8'h3C);
    settle(); rd(0, d); chk("R2 readback driven", d, 8'h3C);
    wr(0, 8'hC3); settle(); rd(0, d); chk("R2 readback second", d, 8'hC3);
  endtask

  task automatic t_dir();
    logic [7:0] d;
    ext_mode = 0; wr(2, 8'h20); chk("R3 compat ignores bit5", pd_oe, 1);
    ext_mode = 1; #1 chk("R3 ext releases", pd_oe, 0);
    ext_drive = 8'hA5; settle(); rd(0, d); chk("R2 readback external", d, 8'hA5);
    wr(2, 8'h00); chk("R3 ext bit5 clear drives", pd_oe, 1);
    ext_mode = 0;
  endtask

  task automatic t_status();
    logic [7:0] d;
    busy_in = 1; ack_n_in = 0; perr_in = 1; sel_in = 0; fault_n_in = 1; settle();
    rd(1, d); chk("R4 status a", d, 8'h28);
    busy_in = 0; ack_n_in = 1; perr_in = 0; sel_in = 1; fault_n_in = 0; settle();
    rd(1, d); chk("R4 status b", d, 8'hD0);
    chk("R5 reserved zero", d[2:0], 0);
    wr(1, 8'hFF); rd(1, d); chk("R5 status write ignored", d, 8'hD0);
    chk("R5 no output change", {pd_out, strobe_n}, {8'hC3, 1'b1});
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr(2, 8'hFF);
    chk("R6 outputs all set", {strobe_n, autofd_n, init_n, selectin_n}, 4'b0010);
    rd(2, d); chk("R6 readback", d, 8'h3F);
    wr(2, 8'h05);
    chk("R6 outputs 05", {strobe_n, autofd_n, init_n, selectin_n}, 4'b0111);
    wr(2, 8'h0A);
    chk("R6 outputs 0A", {strobe_n, autofd_n, init_n, selectin_n}, 4'b1000);
  endtask

  task automatic t_addr3();
    logic [7:0] d;
    wr(3, 8'h77); rd(3, d); chk("R9 addr3 reads 0", d, 0);
    chk("R9 addr3 write ignored", {pd_out, strobe_n}, {8'hC3, 1'b1});
  endtask

  task automatic t_irq();
    int base;
    ack_n_in = 1; wr(2, 8'h00); settle();
    ack_n_in = 0; settle(); base = irq_cycles;
    ack_n_in = 1; settle(); settle();
    chk("R7 disabled no pulse", irq_cycles - base, 0);
    wr(2, 8'h10); base = irq_cycles;
    ack_n_in = 0; settle(); settle();
    chk("R7 falling no pulse", irq_cycles - base, 0);
    ack_n_in = 1; settle(); settle();
    chk("R7 rising one pulse", irq_cycles - base, 1);
    ack_n_in = 0; settle(); ack_n_in = 1; settle(); settle();
    chk("R7 second pulse", irq_cycles - base, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_data();
    t_dir();
    t_status();
    t_ctrl();
    t_addr3();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule